// File: doc/BRIEF.md
# NRZ Output Level Selector with Transition Pre-Emphasis

This block sits between an NRZ bit serializer and a downstream DAC or attenuator. Each time the serializer presents a new bit, the block emits a level code for the bit before it. The code is an unsigned step index in 0.86 dB steps, with index 0 standing for -2.58 dB. A separate polarity flag gives the sign of the bit. The programmed level comes from a host-written 8-bit gain register. That register holds a 3-bit level code, a pre-emphasis enable and four reserved bits that must be zero.

When pre-emphasis is on, the block looks one bit ahead. It raises any bit that is followed by a change of data value by two steps (1.72 dB) above the programmed level. Bits that are followed by the same value stay at the programmed level. The look-ahead needs the following bit, so each output lags the serializer by one bit. The gain register ignores the block reset and keeps whatever the host last wrote.

Top module: `nrz_level_sel`

## Requirements
- R1: After reset, out_valid, out_level and out_neg are 0. The first bit strobe after reset produces no out_valid pulse.
- R2: Every later bit strobe produces exactly one out_valid pulse, on the cycle after the strobe. The pulse describes the bit received before that strobe (one-bit delay), and out_valid is never high otherwise.
- R3: With pre-emphasis off, out_level equals the programmed 3-bit level code (0..6). Index k stands for -2.58 dB + k x 0.86 dB.
- R4: A write whose level field (bits 2:0) is 7 leaves the programmed level unchanged. Its pre-emphasis bit is still taken.
- R5: A write with any of bits 7:4 set is rejected completely: neither the level nor the pre-emphasis enable changes.
- R6: With pre-emphasis enabled (bit 3 = 1), a bit whose successor has the other value is output at the programmed level + 2. This peaks at index 8 (+4.3 dB) for code 6.
- R7: A bit followed by the same value is never boosted. No bit is boosted while pre-emphasis is disabled, and pre-emphasis stays enabled until a write clears bit 3.
- R8: out_neg is 0 for a data 1 and 1 for a data 0 of the bit being output.
- R9: Reset does not alter the gain register: bits after a reset use the setting written before it.
- R10: out_level and out_neg hold their values between out_valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (does not touch the gain register) |
| gain_we | input | 1 | Gain register write strobe |
| gain_wdata | input | 8 | Gain write data: [2:0] level code, [3] pre-emphasis enable, [7:4] reserved, must be 0 |
| bit_valid | input | 1 | One-cycle strobe: a new serializer bit is on bit_in |
| bit_in | input | 1 | Serializer data bit |
| out_valid | output | 1 | One-cycle strobe: a new level code is on the outputs |
| out_level | output | 4 | Step index, 0 = -2.58 dB, 0.86 dB per step |
| out_neg | output | 1 | Polarity of the bit being output (1 = data 0) |

## Verification
Alternating data with pre-emphasis on makes every bit a pre-transition bit, so each one must be boosted. Long runs of equal bits allow only the last bit of each run to be raised, which separates real look-ahead from a fixed boost. The same patterns with pre-emphasis off, and a sweep of all seven level codes, show the programmed level passing through unchanged. Reserved-bit writes, code 7 writes and a reset between bits show which writes the register takes and that the register survives reset.

// File: rtl/nrz_lvl_pkg.sv
package nrz_lvl_pkg;
  // gain register layout
  localparam int GAIN_W   = 8;
  localparam int LVL_W    = 3;
  localparam int PE_BIT   = LVL_W;
  localparam int RSV_LSB  = LVL_W + 1;
  // step index arithmetic
  localparam int BOOST    = 2;
  localparam int TOP_CODE = (1 << LVL_W) - 2;
  localparam int MAX_IDX  = TOP_CODE + BOOST;
  localparam int IDX_W    = $clog2(MAX_IDX + 1);

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             neg;
  } lvl_word_t;

  function automatic logic [IDX_W-1:0] step_index(input logic [LVL_W-1:0] code,
                                                  input logic boost);
    logic [IDX_W-1:0] base;
    base = IDX_W'(code);
    return boost ? base + IDX_W'(BOOST) : base;
  endfunction
endpackage

// File: rtl/nrz_gain_reg.sv
module nrz_gain_reg
  import nrz_lvl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [GAIN_W-1:0] wdata,
  output logic [LVL_W-1:0]  level,
  output logic              pe_en
);
  localparam logic [LVL_W-1:0] UNUSED_CODE = '1;

  logic accept;
  assign accept = we && (wdata[GAIN_W-1:RSV_LSB] == '0);

  // deliberately no reset: the register keeps the host setting
  always_ff @(posedge clk) begin
    if (accept) begin
      pe_en <= wdata[PE_BIT];
      if (wdata[LVL_W-1:0] != UNUSED_CODE)
        level <= wdata[LVL_W-1:0];
    end
  end

  a_r5_reserved_reject: assert property (@(posedge clk) disable iff (rst)
    (we && (wdata[GAIN_W-1:RSV_LSB] != '0)) |=> ($stable(level) && $stable(pe_en)));

  a_r4_unused_code_holds: assert property (@(posedge clk) disable iff (rst)
    (we && (wdata[GAIN_W-1:RSV_LSB] == '0) && (wdata[LVL_W-1:0] == UNUSED_CODE))
      |=> $stable(level));

  a_r7_pe_sticky: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(pe_en));
endmodule

// File: rtl/nrz_lookahead.sv
module nrz_lookahead (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic bit_in,
  output logic cur_bit,
  output logic have_cur,
  output logic emit,
  output logic flip_next
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_bit  <= 1'b0;
      have_cur <= 1'b0;
    end else if (bit_valid) begin
      cur_bit  <= bit_in;
      have_cur <= 1'b1;
    end
  end

  assign emit      = bit_valid && have_cur;
  assign flip_next = emit && (cur_bit != bit_in);

  a_r2_bit_tracks_input: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> (have_cur && (cur_bit == $past(bit_in))));
endmodule

// File: rtl/nrz_level_map.sv
module nrz_level_map
  import nrz_lvl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             emit,
  input  logic             cur_bit,
  input  logic             flip_next,
  input  logic [LVL_W-1:0] level,
  input  logic             pe_en,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_level,
  output logic             out_neg
);
  lvl_word_t nxt;

  always_comb begin
    nxt.idx = step_index(level, pe_en && flip_next);
    nxt.neg = !cur_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_level <= '0;
      out_neg   <= 1'b0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_level <= nxt.idx;
        out_neg   <= nxt.neg;
      end
    end
  end

  a_r6_ceiling: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_level <= IDX_W'(MAX_IDX)));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !emit |=> ($stable(out_level) && $stable(out_neg)));

  a_r3_plain_level: assert property (@(posedge clk) disable iff (rst)
    (emit && !pe_en) |=> (out_level == IDX_W'($past(level))));
endmodule

// File: rtl/nrz_level_sel.sv
module nrz_level_sel
  import nrz_lvl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              gain_we,
  input  logic [GAIN_W-1:0] gain_wdata,
  input  logic              bit_valid,
  input  logic              bit_in,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_level,
  output logic              out_neg
);
  logic [LVL_W-1:0] level;
  logic             pe_en;
  logic             cur_bit, have_cur, emit, flip_next;

  nrz_gain_reg u_gain (
    .clk(clk), .rst(rst), .we(gain_we), .wdata(gain_wdata),
    .level(level), .pe_en(pe_en)
  );

  nrz_lookahead u_look (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .cur_bit(cur_bit), .have_cur(have_cur), .emit(emit), .flip_next(flip_next)
  );

  nrz_level_map u_map (
    .clk(clk), .rst(rst), .emit(emit), .cur_bit(cur_bit), .flip_next(flip_next),
    .level(level), .pe_en(pe_en),
    .out_valid(out_valid), .out_level(out_level), .out_neg(out_neg)
  );

  a_r1_first_bit_silent: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !have_cur) |=> !out_valid);

  a_r2_one_cycle_later: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && have_cur) |=> out_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> !out_valid);

  a_r8_polarity: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && have_cur) |=> (out_neg == !$past(cur_bit)));
endmodule

// File: tb/tb_nrz_level_sel.sv
module tb_nrz_level_sel;
  logic clk = 1'b0;
  logic rst, gain_we, bit_valid, bit_in;
  logic [7:0] gain_wdata;
  logic out_valid, out_neg;
  logic [3:0] out_level;

  always #5 clk = ~clk;

  nrz_level_sel dut (
    .clk(clk), .rst(rst), .gain_we(gain_we), .gain_wdata(gain_wdata),
    .bit_valid(bit_valid), .bit_in(bit_in),
    .out_valid(out_valid), .out_level(out_level), .out_neg(out_neg)
  );

  typedef struct {
    logic [3:0] lvl;
    logic       neg;
    string      tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model of the gain register and look-ahead state
  logic [2:0] m_lvl;
  logic m_pe, m_have, m_prev;
  string cur_tag;

  task automatic fail(string req, string what, int act, int expv);
    bad++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
  endtask

  task automatic write_gain(logic [7:0] d);
    @(negedge clk);
    gain_we = 1'b1; gain_wdata = d;
    if (d[7:4] == 4'd0) begin
      m_pe = d[3];
      if (d[2:0] != 3'd7) m_lvl = d[2:0];
    end
    @(negedge clk);
    gain_we = 1'b0;
  endtask

  task automatic send_bit(logic b);
    exp_t e;
    @(negedge clk);
    bit_valid = 1'b1; bit_in = b;
    if (m_have) begin
      e.lvl = {1'b0, m_lvl} + ((m_pe && (m_prev != b)) ? 4'd2 : 4'd0);
      e.neg = !m_prev;
      e.tag = cur_tag;
      q.push_back(e);
    end
    m_have = 1'b1; m_prev = b;
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic send_pat(logic [15:0] p, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(p[i]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_have = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        // R10: outputs hold between pulses is covered by comparing only on pulses
        if (out_valid) begin
          exp_t e;
          total++;
          if (q.size() == 0) begin
            fail("R2", "unexpected out_valid", 1, 0);
          end else begin
            e = q.pop_front();
            if (out_level !== e.lvl) fail(e.tag, "out_level", int'(out_level), int'(e.lvl));
            if (out_neg !== e.neg) fail(e.tag, "out_neg", int'(out_neg), int'(e.neg));
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] held_lvl;
    logic       held_neg;
    rst = 1'b1; gain_we = 1'b0; gain_wdata = '0; bit_valid = 1'b0; bit_in = 1'b0;
    m_lvl = 3'd0; m_pe = 1'b0; m_have = 1'b0; m_prev = 1'b0; cur_tag = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    total++;
    if (out_valid !== 1'b0 || out_level !== 4'd0 || out_neg !== 1'b0)
      fail("R1", "reset outputs", int'({out_valid, out_level, out_neg}), 0);

    write_gain(8'h03);
    // R1: first bit after reset silent
    send_bit(1'b1);
    total++;
    if (out_valid !== 1'b0) fail("R1", "first bit out_valid", int'(out_valid), 0);

    // R3/R8: plain level, mixed data, pre-emphasis off
    cur_tag = "R3";
    send_pat(16'b1011_0010_0000_0000, 8);

    // R3: sweep all codes, alternating data with pe off -> no boost (R7)
    for (int c = 0; c < 7; c++) begin
      write_gain(8'(c));
      cur_tag = "R7";
      send_pat(16'b0000_0000_0000_1010, 4);
    end

    // R6: pe on, alternating -> every bit boosted; code 6 peaks at 8
    write_gain(8'h0E);
    cur_tag = "R6";
    send_pat(16'b0000_0000_0101_0101, 8);
    write_gain(8'h08);
    send_pat(16'b0000_0000_0000_1010, 4);

    // R7: runs -> only last bit of each run boosted
    write_gain(8'h0B);
    cur_tag = "R7";
    send_pat(16'b0000_1111_0000_1100, 12);

    // R4: code 7 keeps level 3, but pe bit taken (clears pe)
    write_gain(8'h07);
    cur_tag = "R4";
    send_pat(16'b0000_0000_0000_1010, 4);

    // R5: reserved bits set -> rejected, level stays 3, pe stays off
    write_gain(8'h1E);
    write_gain(8'hF9);
    cur_tag = "R5";
    send_pat(16'b0000_0000_0000_1010, 4);

    // R7: pe sticky across writes that keep bit 3 set
    write_gain(8'h09);
    write_gain(8'h0F);
    cur_tag = "R7";
    send_pat(16'b0000_0000_0011_0011, 8);

    // R10: outputs hold while idle
    repeat (2) @(negedge clk);
    held_lvl = out_level; held_neg = out_neg;
    repeat (5) @(negedge clk);
    total++;
    if (out_level !== held_lvl || out_neg !== held_neg)
      fail("R10", "idle hold", int'({out_level, out_neg}), int'({held_lvl, held_neg}));

    // R9: reset keeps gain (level 1, pe on)
    write_gain(8'h09);
    do_reset();
    send_bit(1'b0);
    total++;
    if (out_valid !== 1'b0) fail("R1", "first bit after reset", int'(out_valid), 0);
    cur_tag = "R9";
    send_pat(16'b0000_0000_0000_0110, 4);

    repeat (4) @(negedge clk);
    total++;
    if (q.size() != 0) fail("R2", "missing outputs", 0, q.size());
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule